// File: doc/BRIEF.md
# Integer Execute Unit with Condition Flags

This block is the arithmetic stage of a small 64-bit load/store processor. Each cycle it receives an operation select, two register operands and the raw immediate fields of the instruction. It returns a 64-bit result, which is either an arithmetic value or a memory effective address. Immediate fields are widened inside the block. Unsigned 12-bit constants are zero-extended. Signed 9-bit memory offsets are sign-extended.

The result path is purely combinational. A single shared adder serves all four operations, and a small multiplexer picks its second input. The four condition flags (negative, zero, carry, overflow) are kept in a register. That register is written only by the two register-to-register arithmetic operations, and only when the qualifier input is high. The other operations pass through the block without touching the flags, so a later conditional branch still sees the flags of the last arithmetic compare.

Top module: `exu_top`

## Requirements
- R1: With `op_sel` = 0 (add-immediate), `result` is `opnd_a` plus `imm_u` zero-extended to 64 bits, and `opnd_b` has no effect.
- R2: With `op_sel` = 1 (register add), `result` is `opnd_a + opnd_b` modulo 2^64.
- R3: With `op_sel` = 2 (register subtract), `result` is `opnd_a - opnd_b` modulo 2^64.
- R4: With `op_sel` = 3 (address generation), `result` is `opnd_a` plus `imm_s` sign-extended from bit 8 to 64 bits.
- R5: The flag output `nzcv` is 4'b0000 while `rst_n` is low. Bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V.
- R6: When `op_valid` is high and `op_sel` is 1 or 2, `nzcv` takes new values at the next rising clock edge. N is bit 63 of that cycle's result, and Z is 1 exactly when all 64 result bits are zero.
- R7: C is the carry out of bit 63 for register add. For register subtract, C is 1 when no borrow occurs, that is, when `opnd_a` is greater than or equal to `opnd_b` as unsigned numbers.
- R8: V is 1 when the two addends of the effective addition have the same sign and the sign of the result differs from it. For subtract, the second addend is the bitwise inverse of `opnd_b`.
- R9: `nzcv` keeps its value across a clock edge when `op_sel` is 0 or 3, or when `op_valid` is low. This holds even if the result of such an operation is zero.
- R10: `result` follows the current inputs within the same cycle, with no clock edge needed, and it does not depend on `op_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_valid | input | 1 | Qualifier; a flag-setting operation writes the flags only when this is high |
| op_sel | input | 2 | Operation: 0 add-immediate, 1 register add, 2 register subtract, 3 address generation |
| opnd_a | input | 64 | First register operand |
| opnd_b | input | 64 | Second register operand |
| imm_u | input | 12 | Unsigned immediate for add-immediate |
| imm_s | input | 9 | Signed offset for address generation |
| result | output | 64 | Arithmetic result or effective address |
| nzcv | output | 4 | Registered condition flags {N, Z, C, V} |

## Verification
Two things happen in the same cycle: the flag register captures the outcome of one operation, and the combinational result already shows the next operation. The stimulus table drives vectors back to back with no idle cycles. A flag-setting operation is therefore followed directly by an add-immediate, an address generation, or a qualifier-low subtract. Each vector's result is checked during its own low clock phase, and the flags are checked just after the next rising edge. This confirms that the flags seen alongside a non-flag result still belong to the earlier operation, including the case where that later result is zero. A directed reset during a run and a mid-cycle operand change cover the asynchronous clear and the purely combinational path.

// File: rtl/exu_pkg.sv
package exu_pkg;

   // Operation select encoding; the values are decoded by the neighbouring stage.
   typedef enum logic [1:0] {
      EXU_ADD_IMM  = 2'd0,
      EXU_ADD_REG  = 2'd1,
      EXU_SUB_REG  = 2'd2,
      EXU_ADDR_GEN = 2'd3
   } exu_op_e;

   localparam int EXU_FLAG_W = 4;

   // Bit positions inside the registered flag vector.
   localparam int EXU_FLAG_N = 3;
   localparam int EXU_FLAG_Z = 2;
   localparam int EXU_FLAG_C = 1;
   localparam int EXU_FLAG_V = 0;

   // Adder implementation variants.
   localparam int EXU_ADDER_BEHAV  = 0;
   localparam int EXU_ADDER_RIPPLE = 1;

endpackage

// File: rtl/exu_ext.sv
module exu_ext #(
   parameter int IN_W   = 12,
   parameter int OUT_W  = 64,
   parameter bit SIGNED = 1'b0
) (
   input  logic [IN_W-1:0]  raw,
   output logic [OUT_W-1:0] wide
);
   localparam int PAD_W = OUT_W - IN_W;

   if (IN_W < 1 || PAD_W < 1) begin : g_bad_width
      $error("exu_ext: IN_W must be at least 1 and below OUT_W");
   end

   if (SIGNED) begin : g_sign
      assign wide = {{PAD_W{raw[IN_W-1]}}, raw};
   end else begin : g_zero
      assign wide = {{PAD_W{1'b0}}, raw};
   end

endmodule

// File: rtl/exu_adder.sv
module exu_adder #(
   parameter int DATA_W = 64,
   parameter int STYLE  = 1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              ovf
);
   import exu_pkg::*;

   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("exu_adder: DATA_W must be at least 2");
   end
   if (STYLE != EXU_ADDER_BEHAV && STYLE != EXU_ADDER_RIPPLE) begin : g_bad_style
      $error("exu_adder: unknown STYLE");
   end

   // Subtraction is addition of the inverted operand with carry-in set.
   logic [DATA_W-1:0] b_eff;
   logic              cin;

   assign b_eff = sub ? ~b : b;
   assign cin   = sub;

   if (STYLE == EXU_ADDER_RIPPLE) begin : g_ripple
      logic [DATA_W:0] chain;
      assign chain[0] = cin;

      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         logic prop;
         assign prop       = a[i] ^ b_eff[i];
         assign sum[i]     = prop ^ chain[i];
         assign chain[i+1] = (a[i] & b_eff[i]) | (prop & chain[i]);
      end

      assign cout = chain[DATA_W];

      // R2/R3/R7: the bit-level chain must agree with a wide reference sum.
      logic [DATA_W:0] ref_sum;
      assign ref_sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};

      always_comb begin
         if (!$isunknown({a, b, sub})) begin
            a_r7_chain_matches_reference : assert ({cout, sum} == ref_sum)
               else $error("ripple chain disagrees with reference sum");
         end
      end
   end else begin : g_behav
      assign {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
   end

   // Signed overflow: same-sign addends whose sum changes sign.
   assign ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/exu_flag_reg.sv
module exu_flag_reg #(
   parameter int FLAG_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [FLAG_W-1:0] d,
   output logic [FLAG_W-1:0] q
);

   if (FLAG_W < 1) begin : g_bad_width
      $error("exu_flag_reg: FLAG_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we) begin
         q <= d;
      end
   end

   // R5: held low through reset.
   a_r5_reset_clear : assert property (@(posedge clk) !rst_n |=> q == '0)
      else $error("flag register not cleared by reset");

   // R9: no write, no change.
   a_r9_hold_without_write : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q))
      else $error("flag register changed without a write");

   // R6: a write lands at the next edge.
   a_r6_write_lands : assert property (@(posedge clk) disable iff (!rst_n)
      we |=> q == $past(d))
      else $error("flag register did not capture written value");

endmodule

// File: rtl/exu_top.sv
module exu_top #(
   parameter int DATA_W      = 64,
   parameter int IMM_U_W     = 12,
   parameter int IMM_S_W     = 9,
   parameter int ADDER_STYLE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [1:0]        op_sel,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [IMM_U_W-1:0] imm_u,
   input  logic [IMM_S_W-1:0] imm_s,
   output logic [DATA_W-1:0] result,
   output logic [3:0]        nzcv
);
   import exu_pkg::*;

   localparam int MSB = DATA_W - 1;

   if (IMM_U_W >= DATA_W || IMM_S_W >= DATA_W) begin : g_bad_imm
      $error("exu_top: immediates must be narrower than the datapath");
   end
   if (EXU_FLAG_W != 4) begin : g_bad_flags
      $error("exu_top: flag output assumes four flags");
   end

   exu_op_e op;
   assign op = exu_op_e'(op_sel);

   // ---------------- immediate widening ----------------
   logic [DATA_W-1:0] imm_u_wide;
   logic [DATA_W-1:0] imm_s_wide;

   exu_ext #(.IN_W(IMM_U_W), .OUT_W(DATA_W), .SIGNED(1'b0)) u_ext_u (
      .raw  (imm_u),
      .wide (imm_u_wide)
   );

   exu_ext #(.IN_W(IMM_S_W), .OUT_W(DATA_W), .SIGNED(1'b1)) u_ext_s (
      .raw  (imm_s),
      .wide (imm_s_wide)
   );

   // ---------------- second-operand select ----------------
   logic [DATA_W-1:0] addend_b;
   logic              do_sub;

   always_comb begin
      unique case (op)
         EXU_ADD_IMM:  addend_b = imm_u_wide;
         EXU_ADDR_GEN: addend_b = imm_s_wide;
         default:      addend_b = opnd_b;
      endcase
   end

   assign do_sub = (op == EXU_SUB_REG);

   // ---------------- shared adder ----------------
   logic [DATA_W-1:0] sum;
   logic              carry;
   logic              ovf;

   exu_adder #(.DATA_W(DATA_W), .STYLE(ADDER_STYLE)) u_adder (
      .a    (opnd_a),
      .b    (addend_b),
      .sub  (do_sub),
      .sum  (sum),
      .cout (carry),
      .ovf  (ovf)
   );

   assign result = sum;

   // ---------------- flags ----------------
   logic       flag_op;
   logic       flag_we;
   logic [3:0] flags_next;

   assign flag_op = (op == EXU_ADD_REG) || (op == EXU_SUB_REG);
   assign flag_we = op_valid && flag_op;

   always_comb begin
      flags_next             = '0;
      flags_next[EXU_FLAG_N] = sum[MSB];
      flags_next[EXU_FLAG_Z] = (sum == '0);
      flags_next[EXU_FLAG_C] = carry;
      flags_next[EXU_FLAG_V] = ovf;
   end

   exu_flag_reg #(.FLAG_W(EXU_FLAG_W)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (flag_we),
      .d     (flags_next),
      .q     (nzcv)
   );

   // ---------------- port-level properties ----------------
   // R9: non-flag operations leave the flags alone, whatever their result.
   a_r9_nonflag_ops_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_sel == 2'd0 || op_sel == 2'd3)) |=> $stable(nzcv))
      else $error("flags changed on a non-flag operation");

   // R6: N mirrors the sign of the result that set it.
   a_r6_negative_follows_result : assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_sel == 2'd1 || op_sel == 2'd2)) |=> nzcv[3] == $past(result[MSB]))
      else $error("N flag does not match result sign");

   // R6: Z mirrors an all-zero result.
   a_r6_zero_follows_result : assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_sel == 2'd1 || op_sel == 2'd2)) |=> nzcv[2] == ($past(result) == '0))
      else $error("Z flag does not match result");

   // R7: after subtract, C means the unsigned compare found no borrow.
   a_r7_sub_carry_is_no_borrow : assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 2'd2) |=> nzcv[1] == ($past(opnd_a) >= $past(opnd_b)))
      else $error("C flag after subtract disagrees with unsigned compare");

   // R8: after add, overflow needs equal operand signs.
   a_r8_add_overflow_sign_rule : assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 2'd1 && opnd_a[MSB] != opnd_b[MSB]) |=> !nzcv[0])
      else $error("V flag set for mixed-sign add");

endmodule

// File: tb/tb_exu_top.sv
`timescale 1ns/1ps
module tb_exu_top;

   localparam int  W      = 64;
   localparam time PERIOD = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic [1:0]    op_sel = 2'd0;
   logic [W-1:0]  opnd_a = '0;
   logic [W-1:0]  opnd_b = '0;
   logic [11:0]   imm_u = '0;
   logic [8:0]    imm_s = '0;
   logic [W-1:0]  result;
   logic [3:0]    nzcv;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   exu_top dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op_sel   (op_sel),
      .opnd_a   (opnd_a),
      .opnd_b   (opnd_b),
      .imm_u    (imm_u),
      .imm_s    (imm_s),
      .result   (result),
      .nzcv     (nzcv)
   );

   typedef struct packed {
      logic [1:0]   op;
      logic         vld;
      logic [63:0]  a;
      logic [63:0]  b;
      logic [11:0]  iu;
      logic [8:0]   is;
      logic [63:0]  res;
      logic [3:0]   fl;
      logic [7:0]   req;
   } vec_t;

   localparam int NV = 15;

   // Expected flags are the register contents after the vector's clock edge.
   localparam vec_t VECS [NV] = '{
      // R2/R7: all-ones plus one wraps to zero with carry
      '{2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 12'h0, 9'h0, 64'h0, 4'b0110, 8'd7},
      // R1/R9: B ignored, zero-extended FFF, flags held
      '{2'd0, 1'b1, 64'h5, 64'hDEAD, 12'hFFF, 9'h0, 64'h1004, 4'b0110, 8'd1},
      // R3/R7: 0 - 1 borrows
      '{2'd2, 1'b1, 64'h0, 64'h1, 12'h0, 9'h0, 64'hFFFF_FFFF_FFFF_FFFF, 4'b1000, 8'd3},
      // R4: offset 0x1FF is -1
      '{2'd3, 1'b1, 64'h100, 64'h0, 12'h0, 9'h1FF, 64'hFF, 4'b1000, 8'd4},
      // R8: positive overflow on add
      '{2'd1, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 12'h0, 9'h0, 64'h8000_0000_0000_0000, 4'b1001, 8'd8},
      // R9: subtract with qualifier low leaves flags
      '{2'd2, 1'b0, 64'h5, 64'h5, 12'h0, 9'h0, 64'h0, 4'b1001, 8'd9},
      // R8: negative minus one overflows
      '{2'd2, 1'b1, 64'h8000_0000_0000_0000, 64'h1, 12'h0, 9'h0, 64'h7FFF_FFFF_FFFF_FFFF, 4'b0011, 8'd8},
      // R4: offset 0x100 is -256
      '{2'd3, 1'b1, 64'h1000, 64'h0, 12'h0, 9'h100, 64'hF00, 4'b0011, 8'd4},
      // R6: equal subtract gives zero
      '{2'd2, 1'b1, 64'h5, 64'h5, 12'h0, 9'h0, 64'h0, 4'b0110, 8'd6},
      // R2: small add clears everything
      '{2'd1, 1'b1, 64'h10, 64'h20, 12'h0, 9'h0, 64'h30, 4'b0000, 8'd2},
      // R7: subtract without borrow
      '{2'd2, 1'b1, 64'h30, 64'h10, 12'h0, 9'h0, 64'h20, 4'b0010, 8'd7},
      // R8: two negatives sum to zero with carry and overflow
      '{2'd1, 1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 12'h0, 9'h0, 64'h0, 4'b0111, 8'd8},
      // R4: positive offset 255
      '{2'd3, 1'b1, 64'h40, 64'h0, 12'h0, 9'h0FF, 64'h13F, 4'b0111, 8'd4},
      // R9: add-immediate wraps to zero, Z untouched
      '{2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 12'h1, 9'h0, 64'h0, 4'b0111, 8'd9},
      // R3: 1 - 2
      '{2'd2, 1'b1, 64'h1, 64'h2, 12'h0, 9'h0, 64'hFFFF_FFFF_FFFF_FFFF, 4'b1000, 8'd3}
   };

   task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(PERIOD * 5000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R5: reset state
      repeat (3) @(posedge clk);
      #1;
      check4("R5 flags in reset", nzcv, 4'b0000);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check4("R5 flags after release", nzcv, 4'b0000);

      // Table walk: back-to-back vectors, result in low phase, flags after edge.
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         op_sel   = VECS[i].op;
         op_valid = VECS[i].vld;
         opnd_a   = VECS[i].a;
         opnd_b   = VECS[i].b;
         imm_u    = VECS[i].iu;
         imm_s    = VECS[i].is;
         #5;
         check64($sformatf("R%0d vec %0d result", VECS[i].req, i), result, VECS[i].res);
         @(posedge clk);
         #1;
         check4($sformatf("R%0d vec %0d flags", VECS[i].req, i), nzcv, VECS[i].fl);
      end

      // R10: result follows inputs without a clock edge, independent of op_valid.
      @(negedge clk);
      op_valid = 1'b0;
      op_sel   = 2'd1;
      opnd_a   = 64'h1;
      opnd_b   = 64'h2;
      #2;
      check64("R10 comb result first", result, 64'h3);
      opnd_b = 64'h5;
      #2;
      check64("R10 comb result after change", result, 64'h6);
      op_sel = 2'd0;
      imm_u  = 12'h800;
      #2;
      check64("R10/R1 switch to immediate", result, 64'h801);
      @(posedge clk);
      #1;
      check4("R9 flags after qualifier-low cycle", nzcv, 4'b1000);

      // R5: asynchronous clear mid-run while flags are non-zero.
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check4("R5 async clear", nzcv, 4'b0000);
      @(negedge clk);
      rst_n = 1'b1;

      // R6/R7: flag-setting op right after reset release.
      op_valid = 1'b1;
      op_sel   = 2'd2;
      opnd_a   = 64'h2;
      opnd_b   = 64'h2;
      @(posedge clk);
      #1;
      check4("R6 zero after reset", nzcv, 4'b0110);

      @(negedge clk);
      op_valid = 1'b0;
      repeat (2) @(posedge clk);
      finish_run();
   end

endmodule